// File: doc/BRIEF.md
# Spare Repair Solution Combiner

This block picks one repair option for each fault group of a faulty memory and merges the picks into a single repair plan. The plan must fit within a shared budget of spare rows and spare columns. Each group is loaded with its fault count and up to four candidate options. Each option states how many spare rows and spare columns it consumes. Producing those candidates is the job of another stage. Software or a test controller loads the groups through two write ports while the block is idle, sets the two budgets, and pulses `start`.

Groups with two or more faults take part in the search. They are ordered largest first, and the block walks every combination of one option per group as a set of nested counters, testing one option per cycle. A branch is cut as soon as a partial row sum or column sum exceeds its budget. The lowest-cost feasible combination is kept. Groups with a single fault are handled after the search: each takes one leftover spare, a row if one remains and otherwise a column. The block then reports the chosen option per group, the spares used and a fail flag.

The controller has four states:
- `ST_REST` waits for `start`. On `start` it latches the budgets, the group order and the number of searched groups, then moves to `ST_HUNT`.
- `ST_HUNT` runs the backtracking search. It moves to `ST_TOPUP` at once when no group is searched. Otherwise it moves there when the options of the first-ordered group are used up.
- `ST_TOPUP` visits each group index in turn, one per cycle, and moves to `ST_REPORT` after the last index.
- `ST_REPORT` updates the result outputs, pulses `done` and returns to `ST_REST`.

Top module: `repair_combiner`

## Requirements
- R1: Groups whose fault count is 2 or more are searched in descending fault count. Equal counts go lower group index first. The first-ordered group is the most significant counter of the enumeration.
- R2: A result that does not fail uses no more spare rows than `row_budget` and no more spare columns than `col_budget`.
- R3: Single-fault groups (count 1) are served after the search, in ascending group index. Each takes one spare row while any row is left and otherwise one spare column. Bit g of `single_row` is 1 when group g took a row and 0 in every other case.
- R4: Among the feasible combinations, the one chosen has the smallest sum of rows plus columns over the searched groups.
- R5: `fail` is 1 in three cases: no combination fits both budgets, some searched group has an option count of 0, or a single-fault group finds no spare left. On fail, `used_rows`, `used_cols`, `sel_opt` and `single_row` read 0.
- R6: When several combinations share the minimum cost, the one first in enumeration order is kept. Enumeration takes options in ascending index at every level.
- R7: `done` is high for exactly one cycle per search. All result outputs hold their values until the next `done`.
- R8: A group with fault count 0 is ignored. Its `sel_opt` field reads 0 and it consumes no spares. The field for group g is `sel_opt[2g+1:2g]`.
- R9: After reset, `done`, `fail`, `used_rows`, `used_cols`, `sel_opt` and `single_row` are all 0.
- R10: With no searched group, the result consists only of the single-fault assignments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Write fault count and option count of one group |
| cfg_grp | input | 3 | Group written by cfg_we |
| cfg_faults | input | 4 | Fault count of the group |
| cfg_nopt | input | 3 | Number of valid options (values above 4 read as 4) |
| opt_we | input | 1 | Write one candidate option |
| opt_grp | input | 3 | Group of the option |
| opt_idx | input | 2 | Option slot |
| opt_rows | input | 4 | Spare rows consumed by the option |
| opt_cols | input | 4 | Spare columns consumed by the option |
| start | input | 1 | Begin a search (taken only when idle) |
| row_budget | input | 4 | Spare rows available |
| col_budget | input | 4 | Spare columns available |
| done | output | 1 | One-cycle end-of-search pulse |
| fail | output | 1 | No repair plan fits |
| used_rows | output | 4 | Spare rows used by the plan |
| used_cols | output | 4 | Spare columns used by the plan |
| sel_opt | output | 16 | Chosen option slot per group, 2 bits each |
| single_row | output | 8 | Per group: single-fault group took a row |

## Verification
The search is exercised with mixes of 0 to 4 searched groups holding 1 to 3 options, random single-fault groups and random budgets. A combinational model enumerates every combination and checks the minimum-cost choice and the fail decision. Small directed cases separate the intended behaviour from close alternatives:
- two equal-cost groups whose winner flips if the order were by index instead of by fault count;
- a cheap option placed after an expensive one;
- single-fault groups that first exhaust the rows and then the columns;
- a group with no options;
- an empty group loaded with stale options.

A wide case with six searched groups of four options each runs the backtracking to depth six with pruning.

// File: rtl/rc_pkg.sv
package rc_pkg;
    typedef enum logic [1:0] {
        ST_REST   = 2'd0,
        ST_HUNT   = 2'd1,
        ST_TOPUP  = 2'd2,
        ST_REPORT = 2'd3
    } rc_state_e;
endpackage

// File: rtl/rc_cand_store.sv
module rc_cand_store #(
    parameter int NGRP = 8,
    parameter int NOPT = 4,
    parameter int BW   = 4,
    parameter int FCW  = 4,
    localparam int GW  = $clog2(NGRP),
    localparam int OIW = $clog2(NOPT),
    localparam int OCW = $clog2(NOPT + 1)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_allow,
    input  logic                                 cfg_we,
    input  logic [GW-1:0]                        cfg_grp,
    input  logic [FCW-1:0]                       cfg_faults,
    input  logic [OCW-1:0]                       cfg_nopt,
    input  logic                                 opt_we,
    input  logic [GW-1:0]                        opt_grp,
    input  logic [OIW-1:0]                       opt_idx,
    input  logic [BW-1:0]                        opt_rows,
    input  logic [BW-1:0]                        opt_cols,
    output logic [NGRP-1:0][FCW-1:0]             faults,
    output logic [NGRP-1:0][OCW-1:0]             nopt,
    output logic [NGRP-1:0][NOPT-1:0][BW-1:0]    orows,
    output logic [NGRP-1:0][NOPT-1:0][BW-1:0]    ocols
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            faults <= '0;
            nopt   <= '0;
            orows  <= '0;
            ocols  <= '0;
        end else if (wr_allow) begin
            if (cfg_we) begin
                faults[cfg_grp] <= cfg_faults;
                nopt[cfg_grp]   <= (cfg_nopt > OCW'(NOPT)) ? OCW'(NOPT) : cfg_nopt;
            end
            if (opt_we) begin
                orows[opt_grp][opt_idx] <= opt_rows;
                ocols[opt_grp][opt_idx] <= opt_cols;
            end
        end
    end
endmodule

// File: rtl/rc_order_sort.sv
module rc_order_sort #(
    parameter int NGRP = 8,
    parameter int FCW  = 4,
    localparam int GW  = $clog2(NGRP)
) (
    input  logic [NGRP-1:0][FCW-1:0] faults,
    output logic [NGRP-1:0][GW-1:0]  order,
    output logic [GW:0]              nmulti
);
    logic [NGRP-1:0]         multi;
    logic [NGRP-1:0][GW-1:0] rank_w;

    always_comb begin
        for (int g = 0; g < NGRP; g++) begin
            multi[g] = (faults[g] >= FCW'(2));
        end
    end

    // rank = number of searched groups that precede this one
    always_comb begin
        int cnt;
        for (int g = 0; g < NGRP; g++) begin
            cnt = 0;
            for (int h = 0; h < NGRP; h++) begin
                if (multi[h] && ((faults[h] > faults[g]) ||
                                 ((faults[h] == faults[g]) && (h < g)))) begin
                    cnt++;
                end
            end
            rank_w[g] = GW'(cnt);
        end
    end

    always_comb begin
        int nm;
        order = '0;
        nm    = 0;
        for (int g = 0; g < NGRP; g++) begin
            if (multi[g]) begin
                order[rank_w[g]] = GW'(g);
                nm++;
            end
        end
        nmulti = (GW + 1)'(nm);
    end

    // R1: the first-ordered group never has fewer faults than the second
    always_comb begin
        if (nmulti >= (GW + 1)'(2)) begin
            a_r1_order_desc: assert (faults[order[0]] >= faults[order[1]]);
        end
    end
endmodule

// File: rtl/repair_combiner.sv
module repair_combiner #(
    parameter int NGRP = 8,
    parameter int NOPT = 4,
    parameter int BW   = 4,
    parameter int FCW  = 4,
    localparam int GW  = $clog2(NGRP),
    localparam int OIW = $clog2(NOPT),
    localparam int OCW = $clog2(NOPT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [GW-1:0]        cfg_grp,
    input  logic [FCW-1:0]       cfg_faults,
    input  logic [OCW-1:0]       cfg_nopt,
    input  logic                 opt_we,
    input  logic [GW-1:0]        opt_grp,
    input  logic [OIW-1:0]       opt_idx,
    input  logic [BW-1:0]        opt_rows,
    input  logic [BW-1:0]        opt_cols,
    input  logic                 start,
    input  logic [BW-1:0]        row_budget,
    input  logic [BW-1:0]        col_budget,
    output logic                 done,
    output logic                 fail,
    output logic [BW-1:0]        used_rows,
    output logic [BW-1:0]        used_cols,
    output logic [NGRP*OIW-1:0]  sel_opt,
    output logic [NGRP-1:0]      single_row
);
    import rc_pkg::*;

    rc_state_e state_q, state_d;

    logic [NGRP-1:0][FCW-1:0]          faults;
    logic [NGRP-1:0][OCW-1:0]          nopt;
    logic [NGRP-1:0][NOPT-1:0][BW-1:0] orows;
    logic [NGRP-1:0][NOPT-1:0][BW-1:0] ocols;
    logic [NGRP-1:0][GW-1:0]           order_w;
    logic [GW:0]                       nm_w;

    rc_cand_store #(.NGRP(NGRP), .NOPT(NOPT), .BW(BW), .FCW(FCW)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_allow(state_q == ST_REST),
        .cfg_we(cfg_we), .cfg_grp(cfg_grp), .cfg_faults(cfg_faults), .cfg_nopt(cfg_nopt),
        .opt_we(opt_we), .opt_grp(opt_grp), .opt_idx(opt_idx),
        .opt_rows(opt_rows), .opt_cols(opt_cols),
        .faults(faults), .nopt(nopt), .orows(orows), .ocols(ocols)
    );

    rc_order_sort #(.NGRP(NGRP), .FCW(FCW)) sort_i (
        .faults(faults), .order(order_w), .nmulti(nm_w)
    );

    // latched search context
    logic [BW-1:0]               rb_q, cb_q;
    logic [NGRP-1:0][GW-1:0]     order_q;
    logic [GW:0]                 nm_q;
    // backtracking counters
    logic [GW-1:0]               depth_q;
    logic [NGRP-1:0][OCW-1:0]    idx_q;
    logic [NGRP-1:0][BW-1:0]     prow_q, pcol_q;
    // best combination so far
    logic                        found_q;
    logic [NGRP-1:0][OIW-1:0]    best_lvl_q;
    logic [BW-1:0]               best_r_q, best_c_q;
    // single-fault fill
    logic [GW-1:0]               fi_q;
    logic [BW-1:0]               taken_r_q, taken_c_q;
    logic [NGRP-1:0]             srow_w_q;
    logic                        ffail_q;
    // result registers
    logic                        done_q, fail_q;
    logic [BW-1:0]               rows_q, cols_q;
    logic [NGRP-1:0][OIW-1:0]    sel_q;
    logic [NGRP-1:0]             srow_q;

    // current search step
    logic [GW-1:0]   cur_g;
    logic [OCW-1:0]  cur_idx;
    logic            exhausted, fits, leaf, better;
    logic [BW:0]     cur_r, cur_c;
    logic [BW+1:0]   cur_tot, best_tot;
    logic            fill_single, row_left, col_left;
    logic [NGRP-1:0][OIW-1:0] sel_w;
    logic            fail_w;

    always_comb begin
        cur_g     = order_q[depth_q];
        cur_idx   = idx_q[depth_q];
        exhausted = (cur_idx >= nopt[cur_g]);
        cur_r     = {1'b0, prow_q[depth_q]} + {1'b0, orows[cur_g][cur_idx[OIW-1:0]]};
        cur_c     = {1'b0, pcol_q[depth_q]} + {1'b0, ocols[cur_g][cur_idx[OIW-1:0]]};
        fits      = (cur_r <= {1'b0, rb_q}) && (cur_c <= {1'b0, cb_q});
        leaf      = ({1'b0, depth_q} == (nm_q - 1'b1));
        cur_tot   = {1'b0, cur_r} + {1'b0, cur_c};
        best_tot  = {2'b0, best_r_q} + {2'b0, best_c_q};
        better    = !found_q || (cur_tot < best_tot);
        fill_single = found_q && (faults[fi_q] == FCW'(1));
        row_left  = ({1'b0, best_r_q} + {1'b0, taken_r_q}) < {1'b0, rb_q};
        col_left  = ({1'b0, best_c_q} + {1'b0, taken_c_q}) < {1'b0, cb_q};
        fail_w    = !found_q || ffail_q;
    end

    always_comb begin
        sel_w = '0;
        for (int l = 0; l < NGRP; l++) begin
            if (l < int'(nm_q)) begin
                sel_w[order_q[l]] = best_lvl_q[l];
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_REST;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_REST:   if (start) state_d = ST_HUNT;
            ST_HUNT:   if (nm_q == '0 || (exhausted && depth_q == '0)) state_d = ST_TOPUP;
            ST_TOPUP:  if (fi_q == GW'(NGRP - 1)) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_REST;
            default:   state_d = ST_REST;
        endcase
    end

    // search and fill datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_q <= '0; cb_q <= '0; order_q <= '0; nm_q <= '0;
            depth_q <= '0; idx_q <= '0; prow_q <= '0; pcol_q <= '0;
            found_q <= 1'b0; best_lvl_q <= '0; best_r_q <= '0; best_c_q <= '0;
            fi_q <= '0; taken_r_q <= '0; taken_c_q <= '0; srow_w_q <= '0; ffail_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_REST: if (start) begin
                    rb_q <= row_budget; cb_q <= col_budget;
                    order_q <= order_w; nm_q <= nm_w;
                    depth_q <= '0; idx_q <= '0; prow_q <= '0; pcol_q <= '0;
                    found_q <= 1'b0; best_lvl_q <= '0; best_r_q <= '0; best_c_q <= '0;
                    fi_q <= '0; taken_r_q <= '0; taken_c_q <= '0; srow_w_q <= '0; ffail_q <= 1'b0;
                end
                ST_HUNT: begin
                    if (nm_q == '0) begin
                        found_q <= 1'b1;
                    end else if (exhausted) begin
                        if (depth_q != '0) begin
                            depth_q <= depth_q - 1'b1;
                            idx_q[depth_q - 1'b1] <= idx_q[depth_q - 1'b1] + 1'b1;
                        end
                    end else if (!fits) begin
                        idx_q[depth_q] <= cur_idx + 1'b1;
                    end else if (leaf) begin
                        if (better) begin
                            found_q  <= 1'b1;
                            best_r_q <= cur_r[BW-1:0];
                            best_c_q <= cur_c[BW-1:0];
                            for (int l = 0; l < NGRP; l++) begin
                                best_lvl_q[l] <= (GW'(l) == depth_q) ? cur_idx[OIW-1:0]
                                                                     : idx_q[l][OIW-1:0];
                            end
                        end
                        idx_q[depth_q] <= cur_idx + 1'b1;
                    end else begin
                        prow_q[depth_q + 1'b1] <= cur_r[BW-1:0];
                        pcol_q[depth_q + 1'b1] <= cur_c[BW-1:0];
                        idx_q[depth_q + 1'b1]  <= '0;
                        depth_q <= depth_q + 1'b1;
                    end
                end
                ST_TOPUP: begin
                    if (fill_single) begin
                        if (row_left) begin
                            taken_r_q <= taken_r_q + 1'b1;
                            srow_w_q[fi_q] <= 1'b1;
                        end else if (col_left) begin
                            taken_c_q <= taken_c_q + 1'b1;
                        end else begin
                            ffail_q <= 1'b1;
                        end
                    end
                    fi_q <= fi_q + 1'b1;
                end
                ST_REPORT: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0; fail_q <= 1'b0; rows_q <= '0; cols_q <= '0;
            sel_q <= '0; srow_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_REPORT) begin
                done_q <= 1'b1;
                fail_q <= fail_w;
                rows_q <= fail_w ? '0 : best_r_q + taken_r_q;
                cols_q <= fail_w ? '0 : best_c_q + taken_c_q;
                sel_q  <= fail_w ? '0 : sel_w;
                srow_q <= fail_w ? '0 : srow_w_q;
            end
        end
    end

    assign done       = done_q;
    assign fail       = fail_q;
    assign used_rows  = rows_q;
    assign used_cols  = cols_q;
    assign sel_opt    = sel_q;
    assign single_row = srow_q;

    logic [NGRP-1:0] single_mask;
    always_comb begin
        for (int g = 0; g < NGRP; g++) single_mask[g] = (faults[g] == FCW'(1));
    end

    a_r2_prefix_in_budget: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT && nm_q != '0) |-> (prow_q[depth_q] <= rb_q && pcol_q[depth_q] <= cb_q));
    a_r1_depth_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT && nm_q != '0) |-> ({1'b0, depth_q} < nm_q));
    a_r2_totals_in_budget: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !fail_q) |-> (rows_q <= rb_q && cols_q <= cb_q));
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> ($stable(sel_q) && $stable(rows_q) && $stable(cols_q) &&
                     $stable(fail_q) && $stable(srow_q)));
    a_r3_single_only: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ((srow_q & ~single_mask) == '0));
    a_r5_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && fail_q) |-> (rows_q == '0 && cols_q == '0 && srow_q == '0 && sel_q == '0));
endmodule

// File: tb/repair_combiner_tb_top.sv
module repair_combiner_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, opt_we = 1'b0, start = 1'b0;
    logic [2:0]  cfg_grp = '0, opt_grp = '0, cfg_nopt = '0;
    logic [3:0]  cfg_faults = '0, opt_rows = '0, opt_cols = '0;
    logic [1:0]  opt_idx = '0;
    logic [3:0]  row_budget = '0, col_budget = '0;
    logic        done, fail;
    logic [3:0]  used_rows, used_cols;
    logic [15:0] sel_opt;
    logic [7:0]  single_row;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    int m_f[8];
    int m_n[8];
    int m_r[8][4];
    int m_c[8][4];
    int e_fail, e_rows, e_cols, e_sel, e_srow;

    always #2 clk = ~clk;   // 250 MHz

    repair_combiner dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_grp(cfg_grp), .cfg_faults(cfg_faults),
        .cfg_nopt(cfg_nopt), .opt_we(opt_we), .opt_grp(opt_grp), .opt_idx(opt_idx),
        .opt_rows(opt_rows), .opt_cols(opt_cols), .start(start), .row_budget(row_budget),
        .col_budget(col_budget), .done(done), .fail(fail), .used_rows(used_rows),
        .used_cols(used_cols), .sel_opt(sel_opt), .single_row(single_row)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                fails++;
                $display("FAIL watchdog expired");
                summary();
            end
        end
    end

    task automatic clear_model();
        for (int g = 0; g < 8; g++) begin
            m_f[g] = 0; m_n[g] = 0;
            for (int o = 0; o < 4; o++) begin m_r[g][o] = 0; m_c[g][o] = 0; end
        end
    endtask

    task automatic load_all();
        for (int g = 0; g < 8; g++) begin
            cfg_we = 1'b1; cfg_grp = 3'(g); cfg_faults = 4'(m_f[g]); cfg_nopt = 3'(m_n[g]);
            @(negedge clk);
        end
        cfg_we = 1'b0;
        for (int g = 0; g < 8; g++) begin
            for (int o = 0; o < 4; o++) begin
                opt_we = 1'b1; opt_grp = 3'(g); opt_idx = 2'(o);
                opt_rows = 4'(m_r[g][o]); opt_cols = 4'(m_c[g][o]);
                @(negedge clk);
            end
        end
        opt_we = 1'b0;
    endtask

    // independent model: full enumeration, largest group most significant
    task automatic model(input int rb, input int cb);
        int ord[8]; bit used[8]; int nm; int d[8]; int bd[8];
        int found, br, bc, bt, sr, sc, k, tr, tc, ef, srow, any0;
        nm = 0;
        for (int g = 0; g < 8; g++) begin used[g] = 0; ord[g] = 0; d[g] = 0; bd[g] = 0; end
        for (int r = 0; r < 8; r++) begin
            int best; best = -1;
            for (int g = 0; g < 8; g++)
                if (m_f[g] >= 2 && !used[g] && (best < 0 || m_f[g] > m_f[best])) best = g;
            if (best >= 0) begin ord[nm] = best; used[best] = 1; nm++; end
        end
        found = 0; br = 0; bc = 0; bt = 0;
        if (nm == 0) found = 1;
        else begin
            any0 = 0;
            for (int l = 0; l < nm; l++) if (m_n[ord[l]] == 0) any0 = 1;
            if (!any0) begin
                forever begin
                    sr = 0; sc = 0;
                    for (int l = 0; l < nm; l++) begin
                        sr += m_r[ord[l]][d[l]]; sc += m_c[ord[l]][d[l]];
                    end
                    if (sr <= rb && sc <= cb && (!found || sr + sc < bt)) begin
                        found = 1; br = sr; bc = sc; bt = sr + sc;
                        for (int l = 0; l < nm; l++) bd[l] = d[l];
                    end
                    k = nm - 1;
                    while (k >= 0) begin
                        d[k]++;
                        if (d[k] < m_n[ord[k]]) break;
                        d[k] = 0; k--;
                    end
                    if (k < 0) break;
                end
            end
        end
        tr = 0; tc = 0; ef = !found; srow = 0;
        if (found) begin
            for (int g = 0; g < 8; g++) begin
                if (m_f[g] == 1) begin
                    if (br + tr < rb) begin tr++; srow |= (1 << g); end
                    else if (bc + tc < cb) tc++;
                    else ef = 1;
                end
            end
        end
        e_fail = ef;
        if (ef) begin e_rows = 0; e_cols = 0; e_sel = 0; e_srow = 0; end
        else begin
            e_rows = br + tr; e_cols = bc + tc; e_srow = srow; e_sel = 0;
            for (int l = 0; l < nm; l++) e_sel |= bd[l] << (2 * ord[l]);
        end
    endtask

    task automatic run(input int rb, input int cb, input string tag);
        int n;
        load_all();
        row_budget = 4'(rb); col_budget = 4'(cb); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        chk({tag, " R7 done seen"}, int'(done), 1);
        model(rb, cb);
        chk({tag, " R5 fail"}, int'(fail), e_fail);
        chk({tag, " R2 rows"}, int'(used_rows), e_rows);
        chk({tag, " R2 cols"}, int'(used_cols), e_cols);
        chk({tag, " R4 R6 sel"}, int'(sel_opt), e_sel);
        chk({tag, " R3 single_row"}, int'(single_row), e_srow);
        @(negedge clk);
        chk({tag, " R7 done one cycle"}, int'(done), 0);
        @(negedge clk); @(negedge clk);
        chk({tag, " R7 hold sel"}, int'(sel_opt), e_sel);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 done", int'(done), 0);
        chk("R9 fail", int'(fail), 0);
        chk("R9 totals", int'(used_rows) + int'(used_cols), 0);
        chk("R9 sel", int'(sel_opt), 0);
        chk("R9 single_row", int'(single_row), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R6: equal-cost tie decided by fault-count order
        clear_model();
        m_f[0] = 2; m_n[0] = 2; m_r[0][0] = 2; m_r[0][1] = 1; m_c[0][1] = 1;
        m_f[1] = 5; m_n[1] = 2; m_r[1][0] = 2; m_r[1][1] = 1; m_c[1][1] = 1;
        run(3, 4, "tie");
        chk("R1 group1 first", int'(sel_opt[3:0]), 4'b0001);

        // R4: cheaper option found later wins
        clear_model();
        m_f[0] = 3; m_n[0] = 2; m_r[0][0] = 2; m_c[0][0] = 2; m_r[0][1] = 1;
        run(5, 5, "min");
        chk("R4 picked cheap", int'(sel_opt[1:0]), 1);
        chk("R4 rows", int'(used_rows), 1);

        // R3: singles take rows then columns
        clear_model();
        m_f[0] = 2; m_n[0] = 1; m_r[0][0] = 1;
        m_f[2] = 1; m_f[3] = 1; m_f[5] = 1;
        run(2, 2, "singles");
        chk("R3 row to lowest single", int'(single_row), 8'h04);
        chk("R3 cols", int'(used_cols), 2);

        // R5: singles overflow
        run(1, 1, "overflow");
        chk("R5 overflow fail", int'(fail), 1);

        // R10: only singles
        clear_model();
        m_f[1] = 1; m_f[4] = 1; m_f[6] = 1;
        run(1, 5, "only_singles");
        chk("R10 single_row", int'(single_row), 8'h02);
        chk("R10 cols", int'(used_cols), 2);

        // R5: searched group without options
        clear_model();
        m_f[2] = 4; m_n[2] = 0;
        m_f[3] = 3; m_n[3] = 1;
        run(7, 7, "no_opts");
        chk("R5 empty options fail", int'(fail), 1);

        // R8: empty group with stale options
        clear_model();
        m_f[5] = 0; m_n[5] = 3; m_r[5][0] = 9; m_r[5][1] = 9; m_r[5][2] = 0;
        m_f[6] = 2; m_n[6] = 1; m_c[6][0] = 1;
        run(0, 1, "empty_grp");
        chk("R8 empty sel field", int'(sel_opt[11:10]), 0);
        chk("R8 no spares", int'(used_rows), 0);

        // wide search: six groups, four options
        clear_model();
        for (int g = 0; g < 6; g++) begin
            m_f[g] = 2 + g; m_n[g] = 4;
            for (int o = 0; o < 4; o++) begin m_r[g][o] = (g + o) % 3; m_c[g][o] = (g * o + 1) % 3; end
        end
        m_f[7] = 1;
        run(9, 8, "wide");

        // random sweep
        for (int t = 0; t < 180; t++) begin
            int nm;
            clear_model();
            nm = 0;
            for (int g = 0; g < 8; g++) begin
                int f;
                f = $urandom_range(0, 7);
                if (f >= 2 && nm >= 4) f = $urandom_range(0, 1);
                if (f >= 2) nm++;
                m_f[g] = f;
                m_n[g] = ($urandom_range(0, 19) == 0) ? 0 : $urandom_range(1, 3);
                for (int o = 0; o < 4; o++) begin
                    m_r[g][o] = $urandom_range(0, 3); m_c[g][o] = $urandom_range(0, 3);
                end
            end
            run($urandom_range(0, 9), $urandom_range(0, 9), "sweep");
        end
        summary();
    end
endmodule